// File: doc/BRIEF.md
# ADC Result Register with Window Compare

This block keeps the 16-bit accumulated conversion result of an analog-to-digital converter. A host reads and writes it through a byte-wide register bus. When a conversion finishes, the sequencer presents the new result together with a one-cycle valid strobe, and the block stores it. The host can also load either byte of the accumulator directly, unless the write-block control input is high. On the way out, the stored value is passed through a right shifter. The shift amount comes from a 3-bit justification code, so a host reading the two result bytes sees the value already scaled.

Each time the accumulator changes, the scaled value of the new contents is compared against two 16-bit limits, named greater-than and less-than. The ordering of the two limits alone decides whether a match means "inside the window" or "outside the window". A match sets a sticky flag. The flag can drive an interrupt line or be polled over the bus, and the host clears it by writing a zero to it.

Top module: `adc_result_window`

## Requirements
- R1: A synchronous reset clears the accumulator, both limits and the window flag, so every register address reads 0x00 afterwards.
- R2: A cycle with `conv_valid` high loads `conv_data` into the accumulator at that clock edge.
- R3: A bus write to address 0 loads accumulator bits 7:0 and a write to address 1 loads bits 15:8. The write takes effect when `wr_block` and `conv_valid` are both low.
- R4: While `wr_block` is high, bus writes to addresses 0 and 1 leave the accumulator unchanged and start no comparison.
- R5: When a conversion strobe and a host accumulator write fall in the same cycle, the conversion result is stored and the host byte is dropped.
- R6: Address 0 reads bits 7:0 and address 1 reads bits 15:8 of the accumulator shifted right by the justification code (0 to 4 places). The vacated upper bits are zero, and the upper bits of the low byte come from the lower bits of the stored high byte.
- R7: Justification codes 5, 6 and 7 read the accumulator unshifted.
- R8: The greater-than limit is written and read at addresses 2 (bits 7:0) and 3 (bits 15:8). The less-than limit uses addresses 4 and 5 in the same way. Limit writes are accepted whatever the state of `wr_block`.
- R9: If the less-than limit is numerically above the greater-than limit, a compared value V matches only when GT < V < LT (unsigned).
- R10: Otherwise, including when the two limits are equal, V matches when V < LT or V > GT.
- R11: Comparison happens only in a cycle where the accumulator is loaded by a conversion or an accepted host write. It uses the justified form of the new contents under the code present in that cycle. Changing the limits or the code alone never sets the flag.
- R12: The window flag (address 6, bit 0, also driven on `win_flag`) is set by a match one clock after the loading cycle. It stays set until a bus write to address 6 with bit 0 equal to 0. Writing 1 there has no effect.
- R13: A match and a clearing write in the same cycle leave the flag set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_valid | input | 1 | One-cycle strobe marking a new conversion result |
| conv_data | input | 16 | New accumulated conversion result |
| just_code | input | 3 | Justification code selecting the read/compare right shift |
| wr_block | input | 1 | When high, host writes to the accumulator are refused |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data for `bus_addr`, combinational |
| win_flag | output | 1 | Sticky window match flag |

## Verification
The properties assume that the host never issues a clearing flag write and an accumulator write in a way that depends on ordering inside a cycle. They also assume that `conv_valid` is a plain level sampled at the clock, with `conv_data` meaningful only when it is high. The stimulus keeps every input steady from one falling edge to the next. It raises the strobe for exactly one cycle per result. It combines conversions with host writes and with flag clears only in the specific cycles that exercise the priority rules. Limits are placed so that results land exactly on, just inside and just outside each boundary, in both window orientations, with the justification code changed between loads.

// File: rtl/adc_win_pkg.sv
package adc_win_pkg;

    localparam int RES_W     = 16;
    localparam int BYTE_W    = 8;
    localparam int NUM_BYTES = RES_W / BYTE_W;
    localparam int ADDR_W    = 3;
    localparam int JUST_W    = 3;
    localparam int SHIFT_MAX = 4;

    // register map: result bytes, then greater-than, then less-than, then flag
    localparam int BASE_RES  = 0;
    localparam int BASE_GT   = BASE_RES + NUM_BYTES;
    localparam int BASE_LT   = BASE_GT + NUM_BYTES;
    localparam int ADDR_FLAG = BASE_LT + NUM_BYTES;

    typedef logic [RES_W-1:0]  res_t;
    typedef logic [BYTE_W-1:0] byte_t;

    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
        byte_t             data;
    } bus_req_t;

    typedef struct packed {
        res_t gt;
        res_t lt;
    } win_limits_t;

    typedef enum logic {
        WIN_OUTSIDE = 1'b0,
        WIN_INSIDE  = 1'b1
    } win_mode_e;

    function automatic logic addr_hit(input logic [ADDR_W-1:0] a, input int target);
        return a == ADDR_W'(target);
    endfunction

    function automatic win_mode_e mode_of(input win_limits_t l);
        return (l.lt > l.gt) ? WIN_INSIDE : WIN_OUTSIDE;
    endfunction

    function automatic logic in_region(input res_t v, input win_limits_t l, input win_mode_e m);
        if (m == WIN_INSIDE)
            return (v > l.gt) && (v < l.lt);
        return (v < l.lt) || (v > l.gt);
    endfunction

endpackage

// File: rtl/adc_acc_reg.sv
module adc_acc_reg
    import adc_win_pkg::*;
#(
    parameter int SMAX = SHIFT_MAX,
    parameter int BASE = BASE_RES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              conv_valid,
    input  res_t              conv_data,
    input  bus_req_t          req,
    input  logic              wr_block,
    input  logic [JUST_W-1:0] just_code,
    output res_t              acc_q,
    output res_t              fmt_q,
    output res_t              fmt_d,
    output logic              upd_evt
);

    localparam int NB = NUM_BYTES;
    localparam int BW = BYTE_W;

    logic [NB-1:0] lane_wr;
    res_t          acc_d;
    res_t          shifted_q [SMAX+1];
    res_t          shifted_d [SMAX+1];

    // per-byte host write enables; a conversion or a block input locks them out
    for (genvar b = 0; b < NB; b++) begin : g_lane
        assign lane_wr[b] = req.wr && addr_hit(req.addr, BASE + b) && !wr_block && !conv_valid;
    end

    always_comb begin
        acc_d = acc_q;
        if (conv_valid) begin
            acc_d = conv_data;
        end else begin
            for (int i = 0; i < NB; i++) begin
                if (lane_wr[i])
                    acc_d[i*BW +: BW] = req.data;
            end
        end
    end

    assign upd_evt = conv_valid || (|lane_wr);

    always_ff @(posedge clk) begin
        if (rst)
            acc_q <= '0;
        else if (upd_evt)
            acc_q <= acc_d;
    end

    // candidate shifts of the stored and of the incoming value
    for (genvar s = 0; s <= SMAX; s++) begin : g_shift
        assign shifted_q[s] = acc_q >> s;
        assign shifted_d[s] = acc_d >> s;
    end

    // codes beyond SMAX fall back to the unshifted candidate
    always_comb begin
        fmt_q = shifted_q[0];
        fmt_d = shifted_d[0];
        for (int s = 1; s <= SMAX; s++) begin
            if (int'(just_code) == s) begin
                fmt_q = shifted_q[s];
                fmt_d = shifted_d[s];
            end
        end
    end

endmodule

// File: rtl/adc_limit_regs.sv
module adc_limit_regs
    import adc_win_pkg::*;
#(
    parameter int BASE = BASE_GT
) (
    input  logic        clk,
    input  logic        rst,
    input  bus_req_t    req,
    output win_limits_t lim
);

    localparam int NB     = NUM_BYTES;
    localparam int BW     = BYTE_W;
    localparam int NLIMIT = 2;   // index 0 = greater-than, 1 = less-than

    logic [NLIMIT*RES_W-1:0] lim_flat;

    for (genvar k = 0; k < NLIMIT; k++) begin : g_limit
        for (genvar b = 0; b < NB; b++) begin : g_byte
            byte_t byte_q;
            always_ff @(posedge clk) begin
                if (rst)
                    byte_q <= '0;
                else if (req.wr && addr_hit(req.addr, BASE + k*NB + b))
                    byte_q <= req.data;
            end
            assign lim_flat[(k*NB + b)*BW +: BW] = byte_q;
        end
    end

    assign lim.gt = lim_flat[RES_W-1:0];
    assign lim.lt = lim_flat[2*RES_W-1:RES_W];

endmodule

// File: rtl/adc_window_cmp.sv
module adc_window_cmp
    import adc_win_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        evt,
    input  res_t        value,
    input  win_limits_t lim,
    input  logic        clr,
    output logic        hit,
    output logic        flag
);

    win_mode_e mode;

    assign mode = mode_of(lim);
    assign hit  = evt && in_region(value, lim, mode);

    // a fresh match outranks a clear in the same cycle
    always_ff @(posedge clk) begin
        if (rst)
            flag <= 1'b0;
        else if (hit)
            flag <= 1'b1;
        else if (clr)
            flag <= 1'b0;
    end

endmodule

// File: rtl/adc_result_window.sv
module adc_result_window
    import adc_win_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              conv_valid,
    input  logic [RES_W-1:0]  conv_data,
    input  logic [JUST_W-1:0] just_code,
    input  logic              wr_block,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    output logic              win_flag
);

    localparam int NB = NUM_BYTES;
    localparam int BW = BYTE_W;

    bus_req_t    req;
    res_t        acc_q;
    res_t        fmt_q;
    res_t        fmt_d;
    logic        upd_evt;
    win_limits_t lim;
    logic        flag_clr;
    logic        hit_evt;

    assign req.wr   = bus_wr;
    assign req.addr = bus_addr;
    assign req.data = bus_wdata;

    assign flag_clr = bus_wr && addr_hit(bus_addr, ADDR_FLAG) && !bus_wdata[0];

    adc_acc_reg #(
        .SMAX (SHIFT_MAX),
        .BASE (BASE_RES)
    ) u_acc (
        .clk        (clk),
        .rst        (rst),
        .conv_valid (conv_valid),
        .conv_data  (conv_data),
        .req        (req),
        .wr_block   (wr_block),
        .just_code  (just_code),
        .acc_q      (acc_q),
        .fmt_q      (fmt_q),
        .fmt_d      (fmt_d),
        .upd_evt    (upd_evt)
    );

    adc_limit_regs #(
        .BASE (BASE_GT)
    ) u_lim (
        .clk (clk),
        .rst (rst),
        .req (req),
        .lim (lim)
    );

    adc_window_cmp u_cmp (
        .clk   (clk),
        .rst   (rst),
        .evt   (upd_evt),
        .value (fmt_d),
        .lim   (lim),
        .clr   (flag_clr),
        .hit   (hit_evt),
        .flag  (win_flag)
    );

    always_comb begin
        bus_rdata = '0;
        for (int b = 0; b < NB; b++) begin
            if (addr_hit(bus_addr, BASE_RES + b)) bus_rdata = fmt_q[b*BW +: BW];
            if (addr_hit(bus_addr, BASE_GT + b))  bus_rdata = lim.gt[b*BW +: BW];
            if (addr_hit(bus_addr, BASE_LT + b))  bus_rdata = lim.lt[b*BW +: BW];
        end
        if (addr_hit(bus_addr, ADDR_FLAG))
            bus_rdata = {{(BW-1){1'b0}}, win_flag};
    end

endmodule

// File: rtl/adc_win_chk.sv
module adc_win_chk
    import adc_win_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              conv_valid,
    input res_t              conv_data,
    input logic [JUST_W-1:0] just_code,
    input logic              wr_block,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              wbit0,
    input logic [3:0]        rd_top,
    input logic              win_flag,
    input res_t              acc,
    input logic              hit
);

    logic clr_req;
    logic acc_wr_req;

    assign clr_req    = bus_wr && (bus_addr == ADDR_W'(ADDR_FLAG)) && !wbit0;
    assign acc_wr_req = bus_wr && (bus_addr < ADDR_W'(BASE_GT)) && !wr_block && !conv_valid;

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (acc == '0 && !win_flag));

    assert_conv_load_R2: assert property (@(posedge clk) disable iff (rst)
        conv_valid |=> (acc == $past(conv_data)));

    assert_blocked_write_R4: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && wr_block && !conv_valid) |=> $stable(acc));

    assert_shift_zero_fill_R6: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == ADDR_W'(BASE_RES + NUM_BYTES - 1) && just_code == 3'd4) |-> (rd_top == 4'h0));

    assert_no_event_no_set_R11: assert property (@(posedge clk) disable iff (rst)
        (!win_flag && !conv_valid && !acc_wr_req) |=> !win_flag);

    assert_hit_needs_load_R11: assert property (@(posedge clk) disable iff (rst)
        hit |-> (conv_valid || acc_wr_req));

    assert_flag_sticky_R12: assert property (@(posedge clk) disable iff (rst)
        (win_flag && !clr_req) |=> win_flag);

    assert_match_beats_clear_R13: assert property (@(posedge clk) disable iff (rst)
        hit |=> win_flag);

endmodule

bind adc_result_window adc_win_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .conv_valid (conv_valid),
    .conv_data  (conv_data),
    .just_code  (just_code),
    .wr_block   (wr_block),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .wbit0      (bus_wdata[0]),
    .rd_top     (bus_rdata[7:4]),
    .win_flag   (win_flag),
    .acc        (acc_q),
    .hit        (hit_evt)
);

// File: tb/test_adc_result_window.sv
module test_adc_result_window;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        conv_valid = 1'b0;
    logic [15:0] conv_data = '0;
    logic [2:0]  just_code = '0;
    logic        wr_block = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        win_flag;

    always #5 clk = ~clk;

    adc_result_window i_adc_result_window (
        .clk        (clk),
        .rst        (rst),
        .conv_valid (conv_valid),
        .conv_data  (conv_data),
        .just_code  (just_code),
        .wr_block   (wr_block),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .win_flag   (win_flag)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // behavioural reference
    int m_acc, m_gt, m_lt;
    bit m_flag;

    function automatic int m_shift();
        return (just_code <= 3'd4) ? int'(just_code) : 0;
    endfunction

    function automatic int m_read(input int a);
        int f;
        f = m_acc >> m_shift();
        case (a)
            0: return f & 255;
            1: return (f >> 8) & 255;
            2: return m_gt & 255;
            3: return (m_gt >> 8) & 255;
            4: return m_lt & 255;
            5: return (m_lt >> 8) & 255;
            6: return int'(m_flag);
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin : model
        int  nacc;
        int  v;
        bit  ev;
        bit  h;
        if (rst) begin
            m_acc = 0; m_gt = 0; m_lt = 0; m_flag = 0;
        end else begin
            nacc = m_acc;
            ev = 0;
            h = 0;
            if (conv_valid) begin
                nacc = int'(conv_data); ev = 1;
            end else if (bus_wr && !wr_block && bus_addr == 3'd0) begin
                nacc = (m_acc & 'hFF00) | int'(bus_wdata); ev = 1;
            end else if (bus_wr && !wr_block && bus_addr == 3'd1) begin
                nacc = (m_acc & 'h00FF) | (int'(bus_wdata) << 8); ev = 1;
            end
            if (ev) begin
                v = nacc >> m_shift();
                if (m_lt > m_gt) h = (v > m_gt) && (v < m_lt);
                else             h = (v < m_lt) || (v > m_gt);
            end
            m_acc = nacc;
            if (bus_wr) begin
                case (bus_addr)
                    3'd2: m_gt = (m_gt & 'hFF00) | int'(bus_wdata);
                    3'd3: m_gt = (m_gt & 'h00FF) | (int'(bus_wdata) << 8);
                    3'd4: m_lt = (m_lt & 'hFF00) | int'(bus_wdata);
                    3'd5: m_lt = (m_lt & 'h00FF) | (int'(bus_wdata) << 8);
                    default: ;
                endcase
            end
            if (h) m_flag = 1;
            else if (bus_wr && bus_addr == 3'd6 && !bus_wdata[0]) m_flag = 0;
        end
    end

    // per-cycle comparison against the reference
    always @(negedge clk) begin
        #2;
        if (!rst && !done) begin
            check(win_flag === m_flag, "R12", int'(win_flag), int'(m_flag));
            check(bus_rdata === 8'(m_read(int'(bus_addr))), "R6", int'(bus_rdata), m_read(int'(bus_addr)));
        end
    end

    task automatic cyc(input bit cv, input int cd, input bit w, input int a, input int d);
        @(negedge clk);
        conv_valid = cv; conv_data = cd[15:0];
        bus_wr = w; bus_addr = a[2:0]; bus_wdata = d[7:0];
        @(negedge clk);
        conv_valid = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic conv(input int cd);
        cyc(1, cd, 0, 0, 0);
    endtask

    task automatic wr(input int a, input int d);
        cyc(0, 0, 1, a, d);
    endtask

    task automatic rd(input int a, input int exp, input string tag);
        @(negedge clk);
        bus_addr = a[2:0];
        #3;
        check(bus_rdata === 8'(exp), tag, int'(bus_rdata), exp);
    endtask

    task automatic flag_is(input bit e, input string tag);
        #3;
        check(win_flag === e, tag, int'(win_flag), int'(e));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R1: watchdog expired actual 0x0 expected 0x1");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        rd(0, 'h00, "R1"); rd(1, 'h00, "R1"); rd(3, 'h00, "R1"); rd(6, 'h00, "R1");

        // R2 and R10: equal limits give outside mode, nonzero result matches
        conv('hABCD);
        flag_is(1, "R10");
        rd(0, 'hCD, "R2"); rd(1, 'hAB, "R2");

        // R12: writing 1 keeps flag, writing 0 clears
        wr(6, 'h01); flag_is(1, "R12");
        wr(6, 'h00); flag_is(0, "R12");

        // R6 / R7: justification
        just_code = 3'd4; rd(0, 'hBC, "R6"); rd(1, 'h0A, "R6");
        just_code = 3'd2; rd(0, 'hF3, "R6"); rd(1, 'h2A, "R6");
        just_code = 3'd6; rd(0, 'hCD, "R7"); rd(1, 'hAB, "R7");
        just_code = 3'd7; rd(1, 'hAB, "R7");
        just_code = 3'd0;

        // R3: host byte writes, and they trigger comparison (R11)
        wr(0, 'h34); wr(1, 'h12);
        rd(0, 'h34, "R3"); rd(1, 'h12, "R3");
        flag_is(1, "R11");
        wr(6, 'h00); flag_is(0, "R12");

        // R4 / R8: blocked accumulator writes, limits still writable
        wr_block = 1'b1;
        wr(0, 'hFF); wr(1, 'hEE);
        rd(0, 'h34, "R4"); rd(1, 'h12, "R4");
        flag_is(0, "R4");
        wr(2, 'h00); wr(3, 'h10); wr(4, 'h00); wr(5, 'h20);
        rd(3, 'h10, "R8"); rd(5, 'h20, "R8"); rd(2, 'h00, "R8");
        wr_block = 1'b0;

        // R11: limits now place 0x1234 inside, but no load happened
        flag_is(0, "R11");

        // R5: conversion wins over same-cycle host write
        cyc(1, 'h5555, 1, 0, 'h00);
        rd(0, 'h55, "R5"); rd(1, 'h55, "R5");
        flag_is(0, "R9");

        // R9: inside window 0x1000 < V < 0x2000
        conv('h1800); flag_is(1, "R9");
        wr(6, 'h00);
        conv('h2000); flag_is(0, "R9");
        conv('h1000); flag_is(0, "R9");
        conv('h1001); flag_is(1, "R9");
        wr(6, 'h00);

        // R10: outside window, GT=0x3000 LT=0x1000
        wr(3, 'h30); wr(5, 'h10);
        flag_is(0, "R11");
        conv('h2000); flag_is(0, "R10");
        conv('h3001); flag_is(1, "R10");
        wr(6, 'h00);
        conv('h0FFF); flag_is(1, "R10");
        wr(6, 'h00);
        conv('h1000); flag_is(0, "R10");
        conv('h3000); flag_is(0, "R10");

        // R11: compare uses justified value; GT=0x0100 LT=0x0200 inside
        wr(3, 'h01); wr(5, 'h02);
        just_code = 3'd4;
        flag_is(0, "R11");
        conv('h1800); flag_is(1, "R11");
        wr(6, 'h00);
        just_code = 3'd0;
        conv('h1800); flag_is(0, "R11");

        // R13: match beats a same-cycle clear
        cyc(1, 'h0150, 1, 6, 'h00);
        flag_is(1, "R13");

        // R1: reset in mid-run
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        rd(1, 'h00, "R1"); rd(5, 'h00, "R1");
        flag_is(0, "R1");

        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule